// File: doc/BRIEF.md
# Flash Busy-Status Byte Generator

This block builds the byte that a NOR-style flash model returns on a read while its internal program or erase engine is running, suspended, or has just finished. The engine reports what it is doing: whether it is busy, whether the operation is a program or an erase, whether it is a whole-chip erase, whether an erase was aborted because every selected block is protected, and whether an erase is suspended. The engine also marks completion and failure. The surrounding model reports whether the current read address lies in a block selected for erase, and supplies the bit being programmed and the array data. When no status applies, the block passes the array data through unchanged.

A read is a rising edge of `rd_strobe`, sampled on `clk`. Each read captures exactly one byte onto `rd_data` and pulses `rd_valid` for one cycle. The block does not support back-pressure. Each result exists for one cycle only, and the reader must accept it in that cycle. Two toggle bits advance only on captured reads, so a strobe held high counts as one read. `ready_line` tells the outside world whether the engine is occupied.

The engine must pulse `op_done` (with `op_fail`) in the first cycle in which `eng_busy` is low. After a finished operation, the first read returns a final status byte and later reads return array data. If the operation failed, the status byte is returned on every read until a read/reset command is given.

Top module: `flash_poll_status`

## Requirements
- R1: While a program runs (`eng_busy`=1, `eng_prog`=1), bit 7 of a captured byte is the inverse of `prog_bit`, bit 2 is 1, and bit 3 is 1 unless the erase window is open.
- R2: While an erase runs, or while `prot_abort` is high, bit 7 is 0 and bit 6 toggles. Once `prot_abort` falls with no completion pulse, reads return array data again.
- R3: While an operation is active, bit 6 takes the opposite value on each captured read. A strobe held high for several cycles produces exactly one capture.
- R4: The first read after `op_done` returns bit 7 equal to the last programmed bit (or 1 after an erase) and bit 6 equal to the previous read's bit 6. If no error is set, the reads after it return `array_data`.
- R5: During a block erase, and during a suspend read of an erased block, bit 2 toggles only when `addr_in_erase`=1; otherwise it reads 1. During a chip erase, bit 2 toggles for every address.
- R6: The error bit (bit 5) is set by a failed completion or by a `zero_to_one` pulse. It is cleared by `rd_reset` or by a successful completion; a set and a clear in the same cycle leave it set. After a failed completion, every read returns the status byte until `rd_reset` is given. If the failed operation was an erase, bit 2 toggles on reads of erased blocks.
- R7: Bit 3 reads 0 in every status byte while `erase_window`=1, and 1 otherwise.
- R8: With the erase suspended and no operation running, a read with `addr_in_erase`=1 returns bit 7=1, bit 6=1 and a toggling bit 2. A read with `addr_in_erase`=0 returns `array_data`.
- R9: `ready_line` is 0 in the cycle after any cycle with `eng_busy` or `prot_abort` high, and 1 otherwise. This includes suspend and idle. It is 1 out of reset.
- R10: A byte is captured at the clock edge where `rd_strobe` is first sampled high, and it appears on `rd_data` with `rd_valid`=1 during the following cycle. In every status byte, bits 0, 1 and 4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_busy | input | 1 | Engine is running a program or erase |
| eng_prog | input | 1 | Running operation is a program (else erase) |
| eng_chip | input | 1 | Running erase covers the whole chip |
| prot_abort | input | 1 | Erase aborted because all chosen blocks are protected |
| prog_bit | input | 1 | Bit 7 of the byte being programmed |
| addr_in_erase | input | 1 | Read address lies in a block selected for erase |
| erase_susp | input | 1 | Erase is suspended |
| erase_window | input | 1 | Block-erase acceptance window is open |
| op_done | input | 1 | One-cycle completion pulse |
| op_fail | input | 1 | Completion was a failure (valid with op_done) |
| zero_to_one | input | 1 | Pulse: program tried to raise a 0 to 1 |
| rd_reset | input | 1 | Pulse: read/reset command |
| rd_strobe | input | 1 | Read strobe level; a rising edge is one read |
| array_data | input | DW | Array contents at the read address |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | rd_data holds a new read this cycle |
| ready_line | output | 1 | 1 when the engine is not occupied |

## Verification
A read result is due in the cycle after the clock edge that first samples the strobe high. The ready line follows the engine activity inputs one cycle later. Error and completion state changes at the edge that samples `op_done`, `zero_to_one` or `rd_reset`, and shows on reads captured after that edge. A behavioural model in the bench predicts `rd_valid`, `rd_data` and `ready_line` for every cycle and compares them at the falling edge, half a cycle after the outputs change. Directed reads check each requirement with expected bytes computed by hand: for example, the program-busy read 0xCC, the failed-erase final read 0xE8, and the suspended-block read 0xC8.

// File: rtl/fps_pkg.sv
package fps_pkg;
  // bit positions inside the returned status byte
  localparam int B_POLL  = 7;
  localparam int B_TGL_A = 6;
  localparam int B_ERR   = 5;
  localparam int B_WIN   = 3;
  localparam int B_TGL_B = 2;

  // toggle-bit indices
  localparam int N_TGL = 2;
  localparam int T_A   = 0;
  localparam int T_B   = 1;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_BUSY  = 2'd1,
    SRC_SUSP  = 2'd2,
    SRC_DONE  = 2'd3
  } src_e;
endpackage

// File: rtl/fps_toggle.sv
module fps_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic last
);
  // remembers the value most recently emitted on one toggle bit
  always_ff @(posedge clk) begin
    if (!rst_n)   last <= 1'b0;
    else if (adv) last <= ~last;
  end
endmodule

// File: rtl/fps_err_flag.sv
module fps_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_fail,
  input  logic set_bad,
  input  logic clr_ok,
  input  logic clr_cmd,
  output logic err
);
  logic set_any;
  assign set_any = set_fail | set_bad;

  always_ff @(posedge clk) begin
    if (!rst_n)                 err <= 1'b0;
    else if (set_any)           err <= 1'b1;
    else if (clr_ok | clr_cmd)  err <= 1'b0;
  end

  // R6: a read/reset with no competing set leaves the flag clear
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !set_fail && !set_bad) |=> !err);

  // R6: a failure report always leaves the flag set
  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_fail |=> err);
endmodule

// File: rtl/fps_status_mux.sv
module fps_status_mux
  import fps_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              busy_any,
  input  logic              prog_run,
  input  logic              eng_chip,
  input  logic              prog_bit,
  input  logic              addr_in_erase,
  input  logic              erase_susp,
  input  logic              erase_window,
  input  logic              err,
  input  logic              fin,
  input  logic              last_prog,
  input  logic              last_bit,
  input  logic [N_TGL-1:0]  t_last,
  input  logic [DW-1:0]     array_data,
  output logic [DW-1:0]     stat,
  output logic [N_TGL-1:0]  adv,
  output src_e              src
);
  logic tb_cond;

  always_comb begin
    stat    = '0;
    adv     = '0;
    src     = SRC_ARRAY;
    tb_cond = 1'b0;
    if (busy_any) begin
      src             = SRC_BUSY;
      stat[B_POLL]    = prog_run ? ~prog_bit : 1'b0;
      stat[B_TGL_A]   = ~t_last[T_A];
      adv[T_A]        = 1'b1;
      tb_cond         = !prog_run && (eng_chip || addr_in_erase);
    end else if (erase_susp) begin
      if (addr_in_erase) begin
        src           = SRC_SUSP;
        stat[B_POLL]  = 1'b1;
        stat[B_TGL_A] = 1'b1;
        tb_cond       = 1'b1;
      end
    end else if (fin) begin
      src             = SRC_DONE;
      stat[B_POLL]    = last_prog ? last_bit : 1'b1;
      stat[B_TGL_A]   = t_last[T_A];
      tb_cond         = err && !last_prog && addr_in_erase;
    end

    if (src == SRC_ARRAY) begin
      stat = array_data;
    end else begin
      stat[B_ERR]     = err;
      stat[B_WIN]     = ~erase_window;
      stat[B_TGL_B]   = tb_cond ? ~t_last[T_B] : 1'b1;
      adv[T_B]        = tb_cond;
    end
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fps_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_busy,
  input  logic          eng_prog,
  input  logic          eng_chip,
  input  logic          prot_abort,
  input  logic          prog_bit,
  input  logic          addr_in_erase,
  input  logic          erase_susp,
  input  logic          erase_window,
  input  logic          op_done,
  input  logic          op_fail,
  input  logic          zero_to_one,
  input  logic          rd_reset,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ready_line
);
  logic             strobe_q;
  logic             rise;
  logic             busy_any;
  logic             prog_run;
  logic             last_prog;
  logic             last_bit;
  logic             fin;
  logic             err;
  logic [N_TGL-1:0] t_last;
  logic [N_TGL-1:0] adv;
  logic [DW-1:0]    stat;
  src_e             src;

  assign rise     = rd_strobe & ~strobe_q;
  assign busy_any = eng_busy | prot_abort;
  assign prog_run = eng_busy & eng_prog;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= rd_strobe;
  end

  // remember what kind of operation ran last, for the final status byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_prog <= 1'b0;
      last_bit  <= 1'b0;
    end else if (busy_any) begin
      last_prog <= prog_run;
      last_bit  <= prog_bit;
    end
  end

  // finished-operation state: one final read, or held while an error stands
  always_ff @(posedge clk) begin
    if (!rst_n)                                  fin <= 1'b0;
    else if (busy_any || rd_reset)               fin <= 1'b0;
    else if (op_done)                            fin <= 1'b1;
    else if (rise && src == SRC_DONE && !err)    fin <= 1'b0;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TGL; gi++) begin : g_tgl
      fps_toggle u_tgl (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (rise & adv[gi]),
        .last (t_last[gi])
      );
    end
  endgenerate

  fps_err_flag u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_fail(op_done & op_fail),
    .set_bad (zero_to_one),
    .clr_ok  (op_done & ~op_fail),
    .clr_cmd (rd_reset),
    .err     (err)
  );

  fps_status_mux #(.DW(DW)) u_mux (
    .busy_any     (busy_any),
    .prog_run     (prog_run),
    .eng_chip     (eng_chip),
    .prog_bit     (prog_bit),
    .addr_in_erase(addr_in_erase),
    .erase_susp   (erase_susp),
    .erase_window (erase_window),
    .err          (err),
    .fin          (fin),
    .last_prog    (last_prog),
    .last_bit     (last_bit),
    .t_last       (t_last),
    .array_data   (array_data),
    .stat         (stat),
    .adv          (adv),
    .src          (src)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      ready_line <= 1'b1;
    end else begin
      rd_valid   <= rise;
      ready_line <= ~busy_any;
      if (rise) rd_data <= stat;
    end
  end

  // checker state: what kind of read was captured, and the previous bit 6
  logic cap_prog_q, cap_erase_q, cap_pbit_q, prev_b6, prev_busy;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_prog_q  <= 1'b0;
      cap_erase_q <= 1'b0;
      cap_pbit_q  <= 1'b0;
      prev_b6     <= 1'b0;
      prev_busy   <= 1'b0;
    end else begin
      cap_prog_q  <= rise & prog_run;
      cap_erase_q <= rise & busy_any & ~prog_run;
      cap_pbit_q  <= prog_bit;
      if (rd_valid) begin
        prev_b6   <= rd_data[B_TGL_A];
        prev_busy <= cap_prog_q | cap_erase_q;
      end
    end
  end

  assert_prog_poll_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cap_prog_q) |-> (rd_data[B_POLL] == ~cap_pbit_q));

  assert_erase_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cap_erase_q) |-> !rd_data[B_POLL]);

  assert_toggle_alt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (cap_prog_q || cap_erase_q) && prev_busy) |-> (rd_data[B_TGL_A] != prev_b6));

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy || prot_abort) |=> !ready_line);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (cap_prog_q || cap_erase_q)) |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eng_busy = 0, eng_prog = 0, eng_chip = 0, prot_abort = 0;
  logic       prog_bit = 0, addr_in_erase = 0, erase_susp = 0, erase_window = 0;
  logic       op_done = 0, op_fail = 0, zero_to_one = 0, rd_reset = 0, rd_strobe = 0;
  logic [7:0] array_data = 8'h5A;
  logic [7:0] rd_data;
  logic       rd_valid, ready_line;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_poll_status #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_prog(eng_prog),
    .eng_chip(eng_chip), .prot_abort(prot_abort), .prog_bit(prog_bit),
    .addr_in_erase(addr_in_erase), .erase_susp(erase_susp),
    .erase_window(erase_window), .op_done(op_done), .op_fail(op_fail),
    .zero_to_one(zero_to_one), .rd_reset(rd_reset), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready_line(ready_line)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_sq, m_ta, m_tb, m_err, m_fin, m_lp, m_lb;
  bit       e_valid, e_ready;
  bit [7:0] e_data;

  always @(posedge clk) begin
    bit rise, busy, flip_a, flip_b, ton;
    bit [7:0] b;
    int kind; // 0 array, 1 active, 2 suspended block, 3 final
    if (!rst_n) begin
      m_sq = 0; m_ta = 0; m_tb = 0; m_err = 0; m_fin = 0; m_lp = 0; m_lb = 0;
      e_valid = 0; e_ready = 1; e_data = 0;
    end else begin
      busy = eng_busy || prot_abort;
      rise = rd_strobe && !m_sq;
      flip_a = 0; flip_b = 0; ton = 0; b = 0;
      if (busy) kind = 1;
      else if (erase_susp) kind = addr_in_erase ? 2 : 0;
      else if (m_fin) kind = 3;
      else kind = 0;
      case (kind)
        1: begin
          b[7] = (eng_busy && eng_prog) ? !prog_bit : 1'b0;
          b[6] = !m_ta; flip_a = 1;
          ton = !(eng_busy && eng_prog) && (eng_chip || addr_in_erase);
        end
        2: begin b[7] = 1; b[6] = 1; ton = 1; end
        3: begin
          b[7] = m_lp ? m_lb : 1'b1;
          b[6] = m_ta;
          ton = m_err && !m_lp && addr_in_erase;
        end
        default: ;
      endcase
      if (kind == 0) b = array_data;
      else begin
        b[5] = m_err; b[3] = !erase_window;
        b[2] = ton ? !m_tb : 1'b1; flip_b = ton;
      end
      e_valid = rise;
      if (rise) e_data = b;
      e_ready = !busy;
      if (rise && flip_a) m_ta = !m_ta;
      if (rise && flip_b) m_tb = !m_tb;
      if (busy || rd_reset) m_fin = 0;
      else if (op_done) m_fin = 1;
      else if (rise && kind == 3 && !m_err) m_fin = 0;
      if ((op_done && op_fail) || zero_to_one) m_err = 1;
      else if ((op_done && !op_fail) || rd_reset) m_err = 0;
      if (busy) begin m_lp = eng_busy && eng_prog; m_lb = prog_bit; end
      m_sq = rd_strobe;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 model rd_valid", int'(rd_valid), int'(e_valid));
      chk("R9 model ready_line", int'(ready_line), int'(e_ready));
      if (e_valid) chk("R10 model rd_data", int'(rd_data), int'(e_data));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); v = rd_data;
    chk("R10 one valid per read", int'(rd_valid), 1);
    rd_strobe = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse(input logic f);
    op_done = 1; op_fail = f;
    @(negedge clk);
    op_done = 0; op_fail = 0;
  endtask

  initial begin
    logic [7:0] v;
    int nv;
    repeat (3) @(negedge clk);
    chk("R9 ready after reset", int'(ready_line), 1);
    chk("R10 valid after reset", int'(rd_valid), 0);
    chk("R10 data after reset", int'(rd_data), 0);
    rst_n = 1;
    tick(1);

    rd(v); chk("R4 idle read passes array", int'(v), 8'h5A);

    // program, bit 0 being written
    eng_busy = 1; eng_prog = 1; prog_bit = 0;
    tick(1);
    chk("R9 ready low in program", int'(ready_line), 0);
    rd(v); chk("R1 program status byte", int'(v), 8'hCC);
    chk("R10 reserved bits zero", int'(v & 8'h13), 0);
    rd(v); chk("R3 bit6 alternates", int'(v), 8'h8C);
    nv = 0;
    @(negedge clk); rd_strobe = 1;
    repeat (4) begin @(negedge clk); if (rd_valid) nv++; end
    rd_strobe = 0;
    chk("R3 held strobe gives one read", nv, 1);

    eng_busy = 0; eng_prog = 0;
    done_pulse(0);
    rd(v); chk("R4 final byte after program", int'(v), 8'h4C);
    rd(v); chk("R4 array after final byte", int'(v), 8'h5A);
    chk("R9 ready high when idle", int'(ready_line), 1);

    // block erase with the acceptance window open
    eng_busy = 1; erase_window = 1; addr_in_erase = 1;
    rd(v); chk("R7 window open bit3", int'(v), 8'h04);
    addr_in_erase = 0;
    rd(v); chk("R5 bit2 steady outside erased block", int'(v), 8'h44);
    addr_in_erase = 1;
    rd(v); chk("R5 bit2 toggles in erased block", int'(v), 8'h00);
    erase_window = 0;
    rd(v); chk("R7 window closed bit3", int'(v), 8'h4C);

    // suspend
    eng_busy = 0; erase_susp = 1;
    tick(1);
    chk("R9 ready high in suspend", int'(ready_line), 1);
    rd(v); chk("R8 suspended block read", int'(v), 8'hC8);
    addr_in_erase = 0; array_data = 8'h3C;
    rd(v); chk("R8 other block read", int'(v), 8'h3C);

    // program inside suspend, then it fails
    eng_busy = 1; eng_prog = 1; prog_bit = 1;
    rd(v); chk("R1 program in suspend", int'(v), 8'h0C);
    eng_busy = 0; eng_prog = 0;
    done_pulse(1);

    // resume the erase, which also fails
    erase_susp = 0; eng_busy = 1; addr_in_erase = 1;
    rd(v); chk("R6 error shown during erase", int'(v), 8'h6C);
    eng_busy = 0;
    done_pulse(1);
    rd(v); chk("R6 failed erase final byte", int'(v), 8'hE8);
    rd(v); chk("R6 error status persists", int'(v), 8'hEC);
    rd_reset = 1; tick(1); rd_reset = 0;
    rd(v); chk("R6 read reset returns array", int'(v), 8'h3C);

    // chip erase
    eng_busy = 1; eng_chip = 1; addr_in_erase = 0;
    rd(v); chk("R5 chip erase toggles bit2", int'(v), 8'h08);
    eng_busy = 0; eng_chip = 0;
    done_pulse(0);
    rd(v); chk("R4 final byte after erase", int'(v), 8'h8C);
    rd(v); chk("R4 array after erase", int'(v), 8'h3C);

    // raising a zeroed bit flags an error
    zero_to_one = 1; tick(1); zero_to_one = 0;
    rd(v); chk("R6 idle read still array", int'(v), 8'h3C);
    eng_busy = 1; eng_prog = 1; prog_bit = 1;
    rd(v); chk("R6 zero-to-one error visible", int'(v), 8'h6C);
    eng_busy = 0; eng_prog = 0;
    done_pulse(0);
    rd(v); chk("R6 success clears error", int'(v), 8'hCC);

    // protected-block abort
    prot_abort = 1;
    tick(1);
    chk("R2 ready low during abort", int'(ready_line), 0);
    rd(v); chk("R2 abort status byte", int'(v), 8'h0C);
    rd(v); chk("R2 abort bit6 toggles", int'(v), 8'h4C);
    prot_abort = 0;
    tick(1);
    rd(v); chk("R2 array after abort", int'(v), 8'h3C);

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=ended");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule